// File: doc/BRIEF.md
# Flash Protection and Lock Controller

This block keeps the protection state of an on-chip flash array: one lock bit per fixed-size region and a small set of nonvolatile configuration bits. A single command port sets or clears lock bits and configuration bits, and also judges page write and page erase requests against the lock of the region they address. Every command answers with a one-cycle done pulse and a two-bit status. A separate combinational port reports, in the same cycle, whether any given address falls in a locked region, so a flash controller can gate an access without waiting a clock.

Configuration bit 0 is the security bit. Once set by command it blocks debug-port and programming-port access to memory and registers, and no command can clear it. The only way back is the erase-pin recovery sequence: asserting the pin unlocks every region at once, requests a full array erase, waits for the erase-done handshake and only then drops the security bit. Configuration bit 1 picks the boot mapping: when it is 0 the boot ROM appears at address zero, otherwise the flash does. Unique-ID storage and the user signature page lie outside this block and are never touched by the recovery sequence.

Top module: `flash_guard`

## Requirements
- R1: After reset all lock bits and both configuration bits are 0, so `cmd_done` is 0, `secure_lock` is 0, `boot_rom_map` is 1, `erase_req` and `recov_busy` are 0, and `req_locked` is 0 for every address.
- R2: Command op 1 (lock) with `cmd_arg` < 128 sets the lock of region `cmd_arg`; op 2 (unlock) clears it. `cmd_done` pulses for one cycle in the cycle after the command is presented, with status 0 (accepted).
- R3: Op 5 (page write) and op 6 (page erase) take an address in `cmd_arg`; the region is `cmd_arg[19:13]` (8 KB regions, 1 MB array). If that region is locked the status is 1 (lock violation), else 0.
- R4: `req_locked` equals the lock bit of region `req_addr[19:13]` in the same cycle `req_addr` is applied, with no register in between.
- R5: A lock/unlock with `cmd_arg` >= 128, a configuration op with `cmd_arg` >= 2, and ops 0 and 7 return status 2 (command error) and change no state.
- R6: Op 3 (set configuration bit) with `cmd_arg` 0 sets the security bit, shown on `secure_lock`. Op 4 (clear configuration bit) with `cmd_arg` 0 returns status 2 and leaves the security bit set.
- R7: Ops 3 and 4 with `cmd_arg` 1 set and clear configuration bit 1; `boot_rom_map` is the inverse of that bit.
- R8: When `erase_pin` is sampled high with the sequence idle, all lock bits clear at that edge and `erase_req` and `recov_busy` go high in the next cycle; `erase_req` stays high until `erase_done` is sampled high.
- R9: One cycle after `erase_done` is accepted the security bit is cleared and the sequence returns to idle (`recov_busy` low); configuration bit 1 is not changed by the sequence.
- R10: A command presented while the sequence runs or while `erase_pin` is high gets `cmd_done` with status 3 (busy) and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode (1 lock, 2 unlock, 3 set cfg, 4 clear cfg, 5 write, 6 erase) |
| cmd_arg | input | 20 | Region index, configuration bit index, or byte address |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_status | output | 2 | 0 accepted, 1 lock violation, 2 command error, 3 busy |
| req_addr | input | 20 | Address for the combinational lock lookup |
| req_locked | output | 1 | Region of `req_addr` is locked |
| erase_pin | input | 1 | External erase request, level sensitive |
| erase_req | output | 1 | Full-array erase requested from the flash controller |
| erase_done | input | 1 | Flash controller reports full erase complete |
| recov_busy | output | 1 | Recovery sequence in progress |
| secure_lock | output | 1 | Security bit: debug and programming-port access blocked |
| boot_rom_map | output | 1 | Boot ROM mapped at address zero |

## Verification
The bench aims at the edges of the index checks: region 127 against index 128 and a large out-of-range value, and bit 1 against bit 2; a design with an off-by-one compare would lock a wrong region or accept an invalid index. It clears the security bit by command and expects refusal, since a design that allowed it would defeat the recovery path, and it holds the sequence in its erase phase for several cycles to show the security bit survives until `erase_done`, catching a design that drops it on pin assertion. Commands arriving together with the pin or during the sequence must come back busy with no state change, and a long stream of mixed commands checks that back-to-back done pulses and the region decode of write and erase addresses line up with a behavioural model on every clock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_LOCK    = 3'd1,
    OP_UNLOCK  = 3'd2,
    OP_CFG_SET = 3'd3,
    OP_CFG_CLR = 3'd4,
    OP_WRITE   = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } guard_op_e;

  typedef enum logic [1:0] {
    STAT_OK     = 2'd0,
    STAT_LOCKED = 2'd1,
    STAT_BADCMD = 2'd2,
    STAT_BUSY   = 2'd3
  } guard_stat_e;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_ERASE  = 2'd1,
    RS_CLRSEC = 2'd2
  } recov_state_e;

endpackage

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int IDX_W       = 7,
  parameter int NUM_REGIONS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   clr_all,
  output logic [NUM_REGIONS-1:0] locks
);

  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_REGIONS-1:0] lock_d;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_comb begin
      lock_d[i] = lock_q[i];
      if (clr_all) begin
        lock_d[i] = 1'b0;
      end else if (idx == IDX_W'(i)) begin
        if (set_en)      lock_d[i] = 1'b1;
        else if (clr_en) lock_d[i] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[i] <= 1'b0;
      else        lock_q[i] <= lock_d[i];
    end
  end

  assign locks = lock_q;

  // R8
  all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lock_q == '0));

endmodule

// File: rtl/fg_cfg_bits.sv
module fg_cfg_bits #(
  parameter int CFG_BITS  = 2,
  parameter int CFG_IDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic [CFG_IDX_W-1:0] idx,
  input  logic                 sec_clr,
  output logic [CFG_BITS-1:0]  cfg
);

  logic [CFG_BITS-1:0] cfg_q;
  logic [CFG_BITS-1:0] cfg_d;

  for (genvar i = 0; i < CFG_BITS; i++) begin : g_bit
    if (i == 0) begin : g_security
      always_comb begin
        cfg_d[i] = cfg_q[i];
        if (sec_clr)                              cfg_d[i] = 1'b0;
        else if (set_en && idx == CFG_IDX_W'(i))  cfg_d[i] = 1'b1;
      end
    end else begin : g_plain
      always_comb begin
        cfg_d[i] = cfg_q[i];
        if (idx == CFG_IDX_W'(i)) begin
          if (set_en)      cfg_d[i] = 1'b1;
          else if (clr_en) cfg_d[i] = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= 1'b0;
      else        cfg_q[i] <= cfg_d[i];
    end
  end

  assign cfg = cfg_q;

  // R6
  sec_only_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[0]) |-> $past(sec_clr));

endmodule

// File: rtl/fg_recovery.sv
module fg_recovery
  import flash_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic erase_pin,
  input  logic erase_done,
  output logic erase_req,
  output logic busy,
  output logic clr_locks,
  output logic clr_sec
);

  recov_state_e st_q;
  recov_state_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_IDLE:   if (erase_pin)  st_d = RS_ERASE;
      RS_ERASE:  if (erase_done) st_d = RS_CLRSEC;
      RS_CLRSEC:                 st_d = RS_IDLE;
      default:                   st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign erase_req = (st_q == RS_ERASE);
  assign busy      = (st_q != RS_IDLE);
  assign clr_locks = (st_q == RS_IDLE) && erase_pin;
  assign clr_sec   = (st_q == RS_CLRSEC);

  // R8
  pin_starts_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && erase_pin) |=> erase_req);

  // R9
  clrsec_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sec |=> !busy);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int REGION_SHIFT = 13,
  parameter int CFG_BITS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  output logic              cmd_done,
  output logic [1:0]        cmd_status,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_locked,
  input  logic              erase_pin,
  output logic              erase_req,
  input  logic              erase_done,
  output logic              recov_busy,
  output logic              secure_lock,
  output logic              boot_rom_map
);

  localparam int IDX_W       = ADDR_W - REGION_SHIFT;
  localparam int NUM_REGIONS = 1 << IDX_W;
  localparam int CFG_IDX_W   = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_REGIONS-1:0] locks;
  logic [CFG_BITS-1:0]    cfg;
  logic                   seq_busy;
  logic                   clr_locks;
  logic                   clr_sec;

  logic        lock_set, lock_clr, cfg_set, cfg_clr;
  logic        arg_is_region, arg_is_cfg, cmd_hit;
  guard_op_e   op;
  guard_stat_e stat_d;
  logic        done_q;
  guard_stat_e stat_q;

  assign op            = guard_op_e'(cmd_op);
  assign arg_is_region = (cmd_arg[ADDR_W-1:IDX_W] == '0);
  assign arg_is_cfg    = (cmd_arg < ADDR_W'(CFG_BITS));
  assign cmd_hit       = locks[cmd_arg[ADDR_W-1:REGION_SHIFT]];

  always_comb begin
    lock_set = 1'b0;
    lock_clr = 1'b0;
    cfg_set  = 1'b0;
    cfg_clr  = 1'b0;
    stat_d   = STAT_OK;
    if (seq_busy || erase_pin) begin
      stat_d = STAT_BUSY;
    end else begin
      unique case (op)
        OP_LOCK, OP_UNLOCK: begin
          if (!arg_is_region)        stat_d   = STAT_BADCMD;
          else if (op == OP_LOCK)    lock_set = cmd_valid;
          else                       lock_clr = cmd_valid;
        end
        OP_CFG_SET: begin
          if (!arg_is_cfg) stat_d  = STAT_BADCMD;
          else             cfg_set = cmd_valid;
        end
        OP_CFG_CLR: begin
          if (!arg_is_cfg || cmd_arg == '0) stat_d  = STAT_BADCMD;
          else                              cfg_clr = cmd_valid;
        end
        OP_WRITE, OP_ERASE: begin
          if (cmd_hit) stat_d = STAT_LOCKED;
        end
        default: stat_d = STAT_BADCMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      stat_q <= STAT_OK;
    end else begin
      done_q <= cmd_valid;
      if (cmd_valid) stat_q <= stat_d;
    end
  end

  fg_lock_bank #(
    .IDX_W       (IDX_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) u_locks (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (lock_set),
    .clr_en  (lock_clr),
    .idx     (cmd_arg[IDX_W-1:0]),
    .clr_all (clr_locks),
    .locks   (locks)
  );

  fg_cfg_bits #(
    .CFG_BITS  (CFG_BITS),
    .CFG_IDX_W (CFG_IDX_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (cfg_set),
    .clr_en  (cfg_clr),
    .idx     (cmd_arg[CFG_IDX_W-1:0]),
    .sec_clr (clr_sec),
    .cfg     (cfg)
  );

  fg_recovery u_recov (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .erase_pin  (erase_pin),
    .erase_done (erase_done),
    .erase_req  (erase_req),
    .busy       (seq_busy),
    .clr_locks  (clr_locks),
    .clr_sec    (clr_sec)
  );

  assign cmd_done     = done_q;
  assign cmd_status   = stat_q;
  assign req_locked   = locks[req_addr[ADDR_W-1:REGION_SHIFT]];
  assign recov_busy   = seq_busy;
  assign secure_lock  = cfg[0];
  assign boot_rom_map = ~cfg[CFG_BITS-1];

  // R2
  done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_done |-> $past(cmd_valid));

  // R10
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (recov_busy || erase_pin)) |=> (cmd_status == 2'd3));

  // R4
  lookup_comb_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lock_set && cmd_arg[IDX_W-1:0] == req_addr[ADDR_W-1:REGION_SHIFT] && !clr_locks)
      |=> ($stable(req_addr) -> req_locked));

endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [19:0] cmd_arg;
  logic        cmd_done;
  logic [1:0]  cmd_status;
  logic [19:0] req_addr;
  logic        req_locked;
  logic        erase_pin;
  logic        erase_req;
  logic        erase_done;
  logic        recov_busy;
  logic        secure_lock;
  logic        boot_rom_map;

  always #2 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .req_addr(req_addr), .req_locked(req_locked), .erase_pin(erase_pin),
    .erase_req(erase_req), .erase_done(erase_done), .recov_busy(recov_busy),
    .secure_lock(secure_lock), .boot_rom_map(boot_rom_map)
  );

  int    tests = 0;
  int    fails = 0;
  string tag   = "R1";

  // behavioural reference model
  bit [127:0] m_lock;
  bit [1:0]   m_cfg;
  int         m_phase;   // 0 idle, 1 erasing, 2 clearing security
  bit         m_done;
  int         m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = '0; m_cfg = '0; m_phase = 0; m_done = 0; m_stat = 0;
    end else begin
      automatic bit blocked = (m_phase != 0) || erase_pin;
      automatic int ph = m_phase;
      m_done = cmd_valid;
      if (cmd_valid) begin
        if (blocked) m_stat = 3;
        else begin
          case (cmd_op)
            1, 2: if (cmd_arg >= 128) m_stat = 2;
                  else begin m_stat = 0; m_lock[cmd_arg] = (cmd_op == 1); end
            3:    if (cmd_arg >= 2) m_stat = 2;
                  else begin m_stat = 0; m_cfg[cmd_arg] = 1'b1; end
            4:    if (cmd_arg != 1) m_stat = 2;
                  else begin m_stat = 0; m_cfg[1] = 1'b0; end
            5, 6: m_stat = m_lock[cmd_arg / 8192] ? 1 : 0;
            default: m_stat = 2;
          endcase
        end
      end
      if (ph == 0 && erase_pin) begin m_lock = '0; m_phase = 1; end
      else if (ph == 1 && erase_done) m_phase = 2;
      else if (ph == 2) begin m_cfg[0] = 1'b0; m_phase = 0; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, "cmd_done", cmd_done, m_done);
      if (m_done) chk(tag, "cmd_status", cmd_status, m_stat);
      chk("R6", "secure_lock", secure_lock, m_cfg[0]);
      chk("R7", "boot_rom_map", boot_rom_map, !m_cfg[1]);
      chk("R8", "erase_req", erase_req, m_phase == 1);
      chk("R9", "recov_busy", recov_busy, m_phase != 0);
      chk("R4", "req_locked", req_locked, m_lock[req_addr[19:13]]);
    end
  end

  task automatic cmd(input int op, input int arg);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 20'(arg);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
    req_addr = '0; erase_pin = 1'b0; erase_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    // R1: reset state
    #1;
    chk("R1", "reset secure_lock", secure_lock, 0);
    chk("R1", "reset boot_rom_map", boot_rom_map, 1);
    chk("R1", "reset cmd_done", cmd_done, 0);
    chk("R1", "reset erase_req", erase_req, 0);

    tag = "R2";
    cmd(1, 5); cmd(1, 127); cmd(1, 0); cmd(1, 9); cmd(2, 5);
    tag = "R3";
    cmd(5, 20'hFE000 + 20'h44); cmd(6, 20'h00010); cmd(5, 5 * 8192 + 3);
    cmd(6, 9 * 8192 + 8191); cmd(6, 3 * 8192);
    tag = "R4";
    for (int i = 0; i < 128; i++) begin
      @(posedge clk); #1 req_addr = 20'(i * 8192 + 291);
    end
    tag = "R5";
    cmd(1, 128); cmd(2, 20'hFFFFF); cmd(3, 2); cmd(4, 7); cmd(0, 1); cmd(7, 1);
    tag = "R7";
    cmd(3, 1); cmd(4, 1); cmd(3, 1);
    tag = "R6";
    cmd(3, 0); cmd(4, 0); idle(2);

    tag = "R10";
    @(posedge clk); #1;
    erase_pin = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 20'd40;
    @(posedge clk); #1;
    erase_pin = 1'b0; cmd_valid = 1'b0;
    idle(3);
    cmd(3, 1); cmd(1, 7); cmd(4, 1);
    tag = "R8";
    idle(5);
    @(posedge clk); #1 erase_done = 1'b1;
    @(posedge clk); #1 erase_done = 1'b0;
    tag = "R9";
    idle(4);
    cmd(5, 127 * 8192); cmd(6, 9 * 8192);

    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      automatic int op  = $urandom_range(0, 7);
      automatic int arg = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20'hFFFFF)
                                                      : $urandom_range(0, 130);
      if (op == 5 || op == 6) arg = $urandom_range(0, 20'hFFFFF);
      if (op == 4 && arg == 0) arg = 1;
      @(posedge clk); #1;
      cmd_valid = ($urandom_range(0, 3) != 0); cmd_op = 3'(op); cmd_arg = 20'(arg);
      req_addr = 20'($urandom_range(0, 20'hFFFFF));
    end
    @(posedge clk); #1 cmd_valid = 1'b0;

    tag = "R8";
    cmd(1, 77); cmd(3, 0);
    @(posedge clk); #1 erase_pin = 1'b1;
    @(posedge clk); #1 erase_pin = 1'b0;
    idle(2);
    @(posedge clk); #1 erase_done = 1'b1;
    @(posedge clk); #1 erase_done = 1'b0;
    idle(4);
    req_addr = 20'(77 * 8192);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule